// File: doc/BRIEF.md
# Framebuffer Scanline Fetch Controller

This block produces the memory read requests that keep a display pixel FIFO filled with framebuffer data. Software supplies a frame base address, a byte pitch between lines, the length of one line counted in 16-byte beats, and two FIFO watermarks. The display timing generator marks the start of each frame and each line. From these, the block walks the framebuffer one 16-byte beat at a time and presents a request address that the memory side accepts with an acknowledge.

The pitch is programmed as visible pixels times bits per pixel divided by eight, for example two bytes per pixel for 16-bit colour and four for 32-bit colour. The beat count per line is the line's bit length divided by 128, rounded up. Line length and pitch are kept separate, so a line can be shorter than the distance between line bases.

Fetching uses hysteresis on the FIFO level. A burst of requests begins once the level falls under the low watermark. It continues until the level reaches the high watermark or the line runs out of beats. The reset values software normally writes are 0x24 for the low watermark and 0x3C for the high one.

Top module: `fbf_scanline_fetch`

## Requirements
- R1: After reset `req_valid_o` is 0 and `req_addr_o` is 0, and no request is raised before the first frame-start pulse.
- R2: A frame-start pulse loads `frame_base_i` as both the line base and the request address, visible in the next cycle. A new base written later in the frame has no effect on the address until the next frame-start pulse.
- R3: Each cycle with both `req_valid_o` and `req_ack_i` high advances `req_addr_o` by 16 in the next cycle. With no accepted request and no start pulse, the address holds.
- R4: At most `line_beats_i` requests are accepted per line. After the last one `req_valid_o` stays 0 until the next start pulse. A count of 0 raises no request.
- R5: A line-start pulse sets the request address to the previous line base plus `line_pitch_i` bytes and reloads the beat count. Any beats of the previous line that were not fetched are dropped.
- R6: The fill state is sampled at each clock edge. When `fifo_level_i` is below `fifo_low_i`, requests are allowed from the next cycle. When the level is at or above `fifo_high_i`, `req_valid_o` is 0 in the next cycle. The stop condition wins if both hold.
- R7: While the level lies between the watermarks (at least low, below high), the previous fill-or-stop decision is kept.
- R8: While `ctl_enable_i` is 0, `req_valid_o` is 0 in the same cycle and `req_ack_i` does not move the address.
- R9: When frame-start and line-start pulse in the same cycle, the frame-start action is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable_i | input | 1 | Controller enable |
| frame_base_i | input | ADDR_W (32) | Framebuffer start byte address |
| line_pitch_i | input | SPAN_W (16) | Byte distance between line bases |
| line_beats_i | input | SPAN_W (16) | 16-byte beats fetched per line |
| fifo_low_i | input | LVL_W (8) | Refill watermark |
| fifo_high_i | input | LVL_W (8) | Stop watermark |
| fifo_level_i | input | LVL_W (8) | Current pixel FIFO fill level |
| frame_start_i | input | 1 | Frame-start pulse from timing generator |
| line_start_i | input | 1 | Line-start pulse from timing generator |
| req_ack_i | input | 1 | Memory side accepts the current request |
| req_valid_o | output | 1 | Read request pending |
| req_addr_o | output | ADDR_W (32) | Byte address of the 16-byte beat requested |

## Verification
The hardest case to reach from the ports is a line-start pulse that arrives while a line is only partly fetched. That pulse has to drop the remainder and still reload the full count. The bench accepts one beat, pulses line start, and then counts that exactly the programmed number of beats follow from the new base. A second hard case is the middle band of the FIFO level, where the outcome depends on history. The bench moves the level into that band once from above and once from below, and expects opposite results for the same level value. A base written mid-frame is checked by a line step that must still use the old base.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    // Defaults shared by the top module and its checker
    localparam int unsigned FBF_ADDR_W     = 32;
    localparam int unsigned FBF_SPAN_W     = 16;
    localparam int unsigned FBF_LVL_W      = 8;
    localparam int unsigned FBF_BEAT_BYTES = 16;

    // Hysteresis state of the FIFO refill logic
    typedef enum logic [0:0] {
        FILL_HOLD = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_t;

    // Next fill decision from level and watermarks; stop wins over start
    function automatic fill_state_t fill_next(
        input fill_state_t cur,
        input logic        at_or_above_high,
        input logic        below_low
    );
        fill_state_t nxt;
        nxt = cur;
        if (at_or_above_high)
            nxt = FILL_HOLD;
        else if (below_low)
            nxt = FILL_RUN;
        return nxt;
    endfunction

endpackage

// File: rtl/fbf_watermark.sv
module fbf_watermark
    import fbf_pkg::*;
#(
    parameter int unsigned LVL_W = FBF_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] low_i,
    input  logic [LVL_W-1:0] high_i,
    output logic             fill_on_o
);

    fill_state_t state_q;
    logic        over_high;
    logic        under_low;

    assign over_high = (level_i >= high_i);
    assign under_low = (level_i <  low_i);

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= FILL_HOLD;
        else
            state_q <= fill_next(state_q, over_high, under_low);
    end

    assign fill_on_o = (state_q == FILL_RUN);

endmodule

// File: rtl/fbf_line_walker.sv
module fbf_line_walker
    import fbf_pkg::*;
#(
    parameter int unsigned ADDR_W     = FBF_ADDR_W,
    parameter int unsigned SPAN_W     = FBF_SPAN_W,
    parameter int unsigned BEAT_BYTES = FBF_BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start_i,
    input  logic              line_start_i,
    input  logic [ADDR_W-1:0] frame_base_i,
    input  logic [SPAN_W-1:0] line_pitch_i,
    input  logic [SPAN_W-1:0] line_beats_i,
    input  logic              beat_done_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              line_open_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [SPAN_W-1:0] left;
    } cursor_t;

    cursor_t cur_q;
    cursor_t cur_d;
    logic [ADDR_W-1:0] next_base;

    assign next_base = cur_q.base + ADDR_W'(line_pitch_i);

    always_comb begin
        cur_d = cur_q;
        if (frame_start_i) begin
            cur_d.base = frame_base_i;
            cur_d.addr = frame_base_i;
            cur_d.left = line_beats_i;
        end else if (line_start_i) begin
            cur_d.base = next_base;
            cur_d.addr = next_base;
            cur_d.left = line_beats_i;
        end else if (beat_done_i) begin
            cur_d.addr = cur_q.addr + STEP;
            cur_d.left = cur_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else
            cur_q <= cur_d;
    end

    assign addr_o      = cur_q.addr;
    assign line_open_o = (cur_q.left != '0);

endmodule

// File: rtl/fbf_scanline_fetch.sv
module fbf_scanline_fetch
    import fbf_pkg::*;
#(
    parameter int unsigned ADDR_W     = FBF_ADDR_W,
    parameter int unsigned SPAN_W     = FBF_SPAN_W,
    parameter int unsigned LVL_W      = FBF_LVL_W,
    parameter int unsigned BEAT_BYTES = FBF_BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable_i,
    input  logic [ADDR_W-1:0] frame_base_i,
    input  logic [SPAN_W-1:0] line_pitch_i,
    input  logic [SPAN_W-1:0] line_beats_i,
    input  logic [LVL_W-1:0]  fifo_low_i,
    input  logic [LVL_W-1:0]  fifo_high_i,
    input  logic [LVL_W-1:0]  fifo_level_i,
    input  logic              frame_start_i,
    input  logic              line_start_i,
    input  logic              req_ack_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o
);

    logic fill_on;
    logic line_open;
    logic beat_done;

    fbf_watermark #(
        .LVL_W (LVL_W)
    ) u_wmark (
        .clk       (clk),
        .rst       (rst),
        .level_i   (fifo_level_i),
        .low_i     (fifo_low_i),
        .high_i    (fifo_high_i),
        .fill_on_o (fill_on)
    );

    fbf_line_walker #(
        .ADDR_W     (ADDR_W),
        .SPAN_W     (SPAN_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_walk (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start_i),
        .line_start_i  (line_start_i),
        .frame_base_i  (frame_base_i),
        .line_pitch_i  (line_pitch_i),
        .line_beats_i  (line_beats_i),
        .beat_done_i   (beat_done),
        .addr_o        (req_addr_o),
        .line_open_o   (line_open)
    );

    assign req_valid_o = ctl_enable_i & fill_on & line_open;
    assign beat_done   = req_valid_o & req_ack_i;

endmodule

// File: rtl/fbf_fetch_checker.sv
module fbf_fetch_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SPAN_W     = 16,
    parameter int unsigned LVL_W      = 8,
    parameter int unsigned BEAT_BYTES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_enable_i,
    input logic [ADDR_W-1:0] frame_base_i,
    input logic [SPAN_W-1:0] line_pitch_i,
    input logic [SPAN_W-1:0] line_beats_i,
    input logic [LVL_W-1:0]  fifo_low_i,
    input logic [LVL_W-1:0]  fifo_high_i,
    input logic [LVL_W-1:0]  fifo_level_i,
    input logic              frame_start_i,
    input logic              line_start_i,
    input logic              req_ack_i,
    input logic              req_valid_o,
    input logic [ADDR_W-1:0] req_addr_o
);

    logic [ADDR_W-1:0] base_q;
    logic [SPAN_W-1:0] beats_q;
    logic [SPAN_W-1:0] cap_q;
    logic              any_start;
    logic              spent;

    assign any_start = frame_start_i | line_start_i;
    assign spent     = (beats_q >= cap_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            beats_q <= '0;
            cap_q   <= '0;
        end else begin
            if (frame_start_i)
                base_q <= frame_base_i;
            else if (line_start_i)
                base_q <= base_q + ADDR_W'(line_pitch_i);
            if (any_start) begin
                beats_q <= '0;
                cap_q   <= line_beats_i;
            end else if (req_valid_o && req_ack_i) begin
                beats_q <= beats_q + 1'b1;
            end
        end
    end

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        frame_start_i |=> req_addr_o == $past(frame_base_i)); // R2

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (line_start_i && !frame_start_i) |=>
            req_addr_o == $past(base_q) + ADDR_W'($past(line_pitch_i))); // R5

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ack_i && !any_start) |=>
            req_addr_o == $past(req_addr_o) + ADDR_W'(BEAT_BYTES)); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid_o && req_ack_i) && !any_start) |=> $stable(req_addr_o)); // R3

    AST_LINE_CAP: assert property (@(posedge clk) disable iff (rst)
        spent |-> !req_valid_o); // R4

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (fifo_level_i >= fifo_high_i) |=> !req_valid_o); // R6

    AST_REFILL: assert property (@(posedge clk) disable iff (rst)
        (fifo_level_i < fifo_low_i && fifo_level_i < fifo_high_i) |=>
            (req_valid_o || !ctl_enable_i || spent)); // R6

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable_i |-> !req_valid_o); // R8

endmodule

bind fbf_scanline_fetch fbf_fetch_checker #(
    .ADDR_W     (ADDR_W),
    .SPAN_W     (SPAN_W),
    .LVL_W      (LVL_W),
    .BEAT_BYTES (BEAT_BYTES)
) u_fetch_chk (.*);

// File: tb/test_fbf_scanline_fetch.sv
module test_fbf_scanline_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_enable_i = 1'b0;
    logic [31:0] frame_base_i = '0;
    logic [15:0] line_pitch_i = '0;
    logic [15:0] line_beats_i = '0;
    logic [7:0]  fifo_low_i   = 8'h24;
    logic [7:0]  fifo_high_i  = 8'h3C;
    logic [7:0]  fifo_level_i = '0;
    logic        frame_start_i = 1'b0;
    logic        line_start_i  = 1'b0;
    logic        req_ack_i     = 1'b0;
    logic        req_valid_o;
    logic [31:0] req_addr_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fbf_scanline_fetch i_fbf_scanline_fetch (
        .clk           (clk),
        .rst           (rst),
        .ctl_enable_i  (ctl_enable_i),
        .frame_base_i  (frame_base_i),
        .line_pitch_i  (line_pitch_i),
        .line_beats_i  (line_beats_i),
        .fifo_low_i    (fifo_low_i),
        .fifo_high_i   (fifo_high_i),
        .fifo_level_i  (fifo_level_i),
        .frame_start_i (frame_start_i),
        .line_start_i  (line_start_i),
        .req_ack_i     (req_ack_i),
        .req_valid_o   (req_valid_o),
        .req_addr_o    (req_addr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_frame();
        frame_start_i = 1'b1;
        cyc();
        frame_start_i = 1'b0;
    endtask

    task automatic pulse_line();
        line_start_i = 1'b1;
        cyc();
        line_start_i = 1'b0;
    endtask

    task automatic accept(input int n);
        req_ack_i = 1'b1;
        for (int i = 0; i < n; i++) cyc();
        req_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", 32'(req_valid_o), 0);
        chk("R1 addr after reset", req_addr_o, 32'h0);
        ctl_enable_i = 1'b1;
        cyc(); cyc();
        chk("R1 no request before frame start", 32'(req_valid_o), 0);
    endtask

    task automatic t_stream();
        frame_base_i = 32'h1000;
        line_pitch_i = 16'h0140;
        line_beats_i = 16'd3;
        pulse_frame();
        chk("R2 frame base loaded", req_addr_o, 32'h1000);
        chk("R2 request raised", 32'(req_valid_o), 1);
        req_ack_i = 1'b1;
        cyc();
        chk("R3 first step", req_addr_o, 32'h1010);
        cyc();
        chk("R3 second step", req_addr_o, 32'h1020);
        cyc();
        req_ack_i = 1'b0;
        chk("R4 line exhausted", 32'(req_valid_o), 0);
        chk("R3 addr after last beat", req_addr_o, 32'h1030);
        cyc(); cyc();
        chk("R4 stall holds", 32'(req_valid_o), 0);
        pulse_line();
        chk("R5 next line base", req_addr_o, 32'h1140);
        chk("R5 request resumes", 32'(req_valid_o), 1);
    endtask

    task automatic t_abandon();
        accept(1);
        chk("R3 partial beat", req_addr_o, 32'h1150);
        pulse_line();
        chk("R5 remainder dropped", req_addr_o, 32'h1280);
        accept(3);
        chk("R5 full count reloaded", req_addr_o, 32'h12B0);
        chk("R4 stop after reloaded count", 32'(req_valid_o), 0);
    endtask

    task automatic t_base_change();
        frame_base_i = 32'h8000;
        pulse_line();
        chk("R2 mid-frame base ignored", req_addr_o, 32'h13C0);
        pulse_frame();
        chk("R2 new base at frame start", req_addr_o, 32'h8000);
        frame_base_i = 32'h9000;
        frame_start_i = 1'b1;
        line_start_i  = 1'b1;
        cyc();
        frame_start_i = 1'b0;
        line_start_i  = 1'b0;
        chk("R9 frame start wins", req_addr_o, 32'h9000);
    endtask

    task automatic t_hysteresis();
        fifo_level_i = 8'h3C;
        cyc();
        chk("R6 stop at high watermark", 32'(req_valid_o), 0);
        fifo_level_i = 8'h30;
        cyc();
        chk("R7 stays stopped in band", 32'(req_valid_o), 0);
        accept(1);
        chk("R3 ack without request ignored", req_addr_o, 32'h9000);
        fifo_level_i = 8'h23;
        cyc();
        chk("R6 refill below low", 32'(req_valid_o), 1);
        fifo_level_i = 8'h30;
        cyc();
        chk("R7 keeps fetching in band", 32'(req_valid_o), 1);
        fifo_level_i = 8'h3B;
        cyc();
        chk("R7 keeps fetching below high", 32'(req_valid_o), 1);
    endtask

    task automatic t_enable();
        ctl_enable_i = 1'b0;
        #1;
        chk("R8 disable drops request", 32'(req_valid_o), 0);
        accept(1);
        chk("R8 ack ignored while disabled", req_addr_o, 32'h9000);
        ctl_enable_i = 1'b1;
        #1;
        chk("R8 request back on enable", 32'(req_valid_o), 1);
    endtask

    task automatic t_zero_beats();
        line_beats_i = 16'd0;
        pulse_line();
        chk("R4 zero beats address", req_addr_o, 32'h9140);
        chk("R4 zero beats no request", 32'(req_valid_o), 0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(); cyc(); cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_stream();
        t_abandon();
        t_base_change();
        t_hysteresis();
        t_enable();
        t_zero_beats();
        cyc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule